// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block is the synchronous control core of a synchronous buck half-bridge. It takes a logic-level PWM command and produces two gate enables, one for the high-side switch and one for the low-side switch. The two enables are never both active. A switch is turned on only once sensed feedback shows that the opposite switch has actually turned off, so dead time adapts to the real switching speed instead of being a fixed worst-case delay.

Two comparator flags arrive from the analog front end: one says the switch node has fallen low, the other says the low-side gate voltage has fallen low. Both pass through a two-stage synchronizer before use. When the inductor current is negative the switch node may never fall after the high side opens, so a recirculation watchdog forces the low side on after a parameterised number of cycles. A supervisor enable holds both switches off whenever it is low. A PWM reversal during a dead-time wait abandons that wait and starts the opposite sequence.

Top module: `halfbridge_dt_seq`

## Requirements
- R1: `hi_gate_en` and `lo_gate_en` are never 1 in the same cycle.
- R2: While `rst_n` is low both gate enables are 0, and after reset the sequencer sits with both enables 0 until `run_en` and the PWM command move it.
- R3: When `pwm_cmd` is 0 at a clock edge while `hi_gate_en` is 1, `hi_gate_en` is 0 after that edge.
- R4: After the high side opens, `lo_gate_en` goes to 1 only once the synchronized switch-node-low flag is 1 (or R7 applies); with `pwm_cmd` held 0 and the raw flag rising before edge k, `lo_gate_en` is 1 after edge k+2.
- R5: When `pwm_cmd` is 1 at a clock edge while `lo_gate_en` is 1, `lo_gate_en` is 0 after that edge.
- R6: After the low side opens, `hi_gate_en` goes to 1 only once the synchronized low-side-gate-low flag is 1; while that raw flag stays 0, `hi_gate_en` stays 0 however long `pwm_cmd` stays 1.
- R7: If the switch-node flag never arrives, `lo_gate_en` is forced to 1 exactly `WD_CYCLES` clock edges after the edge at which the sequencer entered the wait for the low side (default 16).
- R8: A `pwm_cmd` reversal during a dead-time wait cancels that wait, starts the opposite wait with both enables 0, and a later return to the low-side wait restarts the watchdog count from zero.
- R9: When `run_en` is 0 at an edge both enables are 0 after it and stay 0 regardless of `pwm_cmd`; after `run_en` returns to 1 the sequencer starts again from the both-off state.
- R10: Each raw feedback flag is registered twice before it can gate a turn-on: a flag that first becomes 1 before edge k can turn a gate on no earlier than edge k+2, and the gate outputs follow the cycle rules of R3 to R9 for any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Supervisor enable; 0 holds both switches off |
| pwm_cmd | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| sw_node_low_raw | input | 1 | Comparator flag, switch node below its low threshold (asynchronous) |
| lo_gate_low_raw | input | 1 | Comparator flag, low-side gate voltage below its off threshold (asynchronous) |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach is a PWM reversal in the middle of a watchdog wait followed by a second entry into that wait, because the watchdog must be seen restarting rather than resuming. The stimulus holds the switch-node flag low so the low side can only come on by timeout, flips the command to high partway through the count while the low-side-gate flag is also held low so the high side cannot take over, then flips back and measures the full timeout from the second entry. A long pseudo-random sweep over command, flags and enable is then compared every cycle with a cycle model written from the requirements.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  // Sequencer phases. Only PH_HI_ON and PH_LO_ON drive a gate.
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_HI_ON   = 3'd1,
    PH_WAIT_LO = 3'd2,
    PH_LO_ON   = 3'd3,
    PH_WAIT_HI = 3'd4
  } phase_e;

  // Width needed to hold a count from 0 up to limit.
  function automatic int cnt_width(input int limit);
    int w;
    w = 1;
    while ((1 << w) <= limit) w++;
    return w;
  endfunction

  // Gate decode from phase.
  function automatic logic drives_hi(input phase_e ph);
    return (ph == PH_HI_ON);
  endfunction

  function automatic logic drives_lo(input phase_e ph);
    return (ph == PH_LO_ON);
  endfunction

  // True while the sequencer is waiting for a turn-on permission.
  function automatic logic is_wait(input phase_e ph);
    return (ph == PH_WAIT_LO) || (ph == PH_WAIT_HI);
  endfunction

endpackage

// File: rtl/hbdt_flag_sync.sv
module hbdt_flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  // One register chain per flag.
  for (genvar b = 0; b < WIDTH; b++) begin : g_flag
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q[0] <= raw_i[b];
        for (int s = 1; s < STAGES; s++) begin
          chain_q[s] <= chain_q[s-1];
        end
      end
    end

    assign sync_o[b] = chain_q[LAST];
  end

endmodule

// File: rtl/hbdt_recirc_wd.sv
module hbdt_recirc_wd #(
  parameter int WD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,   // sequencer is waiting for the low side
  output logic fire_o     // timeout reached: force the low side on
);

  localparam int CW = hbdt_pkg::cnt_width(WD_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(WD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LAST_CNT);
  assign fire_o   = armed_i && at_limit;

  // Count cycles spent armed, restart at zero whenever disarmed,
  // hold at the limit.
  always_comb begin
    if (!armed_i) begin
      cnt_d = '0;
    end else if (at_limit) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hbdt_phase_fsm.sv
module hbdt_phase_fsm
  import hbdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  logic   pwm_cmd,
  input  logic   sw_low_s,     // synchronized switch-node-low flag
  input  logic   lg_low_s,     // synchronized low-side-gate-low flag
  input  logic   wd_fire,      // recirculation watchdog timeout
  output phase_e phase_o,
  output logic   hi_en_o,
  output logic   lo_en_o
);

  phase_e phase_q;
  phase_e phase_d;
  logic   lo_permit;
  logic   hi_permit;

  assign lo_permit = sw_low_s || wd_fire;
  assign hi_permit = lg_low_s;

  always_comb begin
    phase_d = phase_q;
    if (!run_en) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = pwm_cmd ? PH_WAIT_HI : PH_WAIT_LO;
        end
        PH_HI_ON: begin
          if (!pwm_cmd) phase_d = PH_WAIT_LO;
        end
        PH_WAIT_LO: begin
          // A reversal wins over a pending permission.
          if (pwm_cmd)        phase_d = PH_WAIT_HI;
          else if (lo_permit) phase_d = PH_LO_ON;
        end
        PH_LO_ON: begin
          if (pwm_cmd) phase_d = PH_WAIT_HI;
        end
        PH_WAIT_HI: begin
          if (!pwm_cmd)       phase_d = PH_WAIT_LO;
          else if (hi_permit) phase_d = PH_HI_ON;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
  assign hi_en_o = drives_hi(phase_q);
  assign lo_en_o = drives_lo(phase_q);

endmodule

// File: rtl/halfbridge_dt_seq.sv
module halfbridge_dt_seq
  import hbdt_pkg::*;
#(
  parameter int WD_CYCLES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic pwm_cmd,
  input  logic sw_node_low_raw,
  input  logic lo_gate_low_raw,
  output logic hi_gate_en,
  output logic lo_gate_en
);

  localparam int NFLAGS = 2;
  localparam int F_SW   = 0;
  localparam int F_LG   = 1;

  // Named internal events, observed by the bound checker.
  logic [NFLAGS-1:0] flags_raw;
  logic [NFLAGS-1:0] flags_s;
  logic              sw_low_s;
  logic              lg_low_s;
  logic              wd_armed;
  logic              wd_fire;
  phase_e            phase;

  assign flags_raw[F_SW] = sw_node_low_raw;
  assign flags_raw[F_LG] = lo_gate_low_raw;
  assign sw_low_s        = flags_s[F_SW];
  assign lg_low_s        = flags_s[F_LG];
  assign wd_armed        = (phase == PH_WAIT_LO);

  hbdt_flag_sync #(
    .WIDTH  (NFLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (flags_raw),
    .sync_o (flags_s)
  );

  hbdt_recirc_wd #(
    .WD_CYCLES (WD_CYCLES)
  ) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_i (wd_armed),
    .fire_o  (wd_fire)
  );

  hbdt_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .pwm_cmd  (pwm_cmd),
    .sw_low_s (sw_low_s),
    .lg_low_s (lg_low_s),
    .wd_fire  (wd_fire),
    .phase_o  (phase),
    .hi_en_o  (hi_gate_en),
    .lo_en_o  (lo_gate_en)
  );

endmodule

// File: rtl/halfbridge_dt_seq_chk.sv
module halfbridge_dt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic pwm_cmd,
  input logic sw_low_s,
  input logic lg_low_s,
  input logic wd_fire,
  input logic hi_gate_en,
  input logic lo_gate_en
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate_en && lo_gate_en));

  a_r3_hi_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate_en && !pwm_cmd) |=> !hi_gate_en);

  a_r5_lo_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate_en && pwm_cmd) |=> !lo_gate_en);

  a_r4_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate_en) |-> $past(sw_low_s || wd_fire));

  a_r6_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate_en) |-> $past(lg_low_s));

  a_r7_wd_forces_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && run_en && !pwm_cmd) |=> lo_gate_en);

  a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!hi_gate_en && !lo_gate_en));

  // R2: reset holds both gates off.
  always_comb begin
    if (!rst_n) begin
      a_r2_reset_off: assert (!hi_gate_en && !lo_gate_en);
    end
  end

endmodule

bind halfbridge_dt_seq halfbridge_dt_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .pwm_cmd    (pwm_cmd),
  .sw_low_s   (sw_low_s),
  .lg_low_s   (lg_low_s),
  .wd_fire    (wd_fire),
  .hi_gate_en (hi_gate_en),
  .lo_gate_en (lo_gate_en)
);

// File: tb/halfbridge_dt_seq_bench.sv
module halfbridge_dt_seq_bench;

  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic pwm = 1'b0;
  logic sw_raw = 1'b0;
  logic lg_raw = 1'b0;
  logic hi, lo;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit sweep_on = 1'b0;

  always #5 clk = ~clk;

  halfbridge_dt_seq #(.WD_CYCLES(WD)) u_halfbridge_dt_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .run_en          (run_en),
    .pwm_cmd         (pwm),
    .sw_node_low_raw (sw_raw),
    .lo_gate_low_raw (lg_raw),
    .hi_gate_en      (hi),
    .lo_gate_en      (lo)
  );

  // Cycle model written from the requirements.
  // mode: 0 both off, 1 high on, 2 waiting for low, 3 low on, 4 waiting for high
  int mode = 0;
  int waited = 0;
  bit sw1 = 0, sw2 = 0, lg1 = 0, lg2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; waited = 0; sw1 = 0; sw2 = 0; lg1 = 0; lg2 = 0;
    end else begin
      int nxt;
      nxt = mode;
      if (!run_en) nxt = 0;
      else if (mode == 0) nxt = pwm ? 4 : 2;
      else if (mode == 1) begin if (!pwm) nxt = 2; end
      else if (mode == 3) begin if (pwm) nxt = 4; end
      else if (mode == 2) begin
        if (pwm) nxt = 4;
        else if (sw2 || waited == WD - 1) nxt = 3;
      end else begin
        if (!pwm) nxt = 2;
        else if (lg2) nxt = 1;
      end
      if (mode == 2) waited = (waited >= WD - 1) ? waited : waited + 1;
      else waited = 0;
      mode = nxt;
      sw2 = sw1; sw1 = sw_raw;
      lg2 = lg1; lg1 = lg_raw;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hi_on();
    int k;
    for (k = 0; k < 60 && hi !== 1'b1; k++) tick(1);
    chk("R6", "high side reached", hi, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Per-cycle comparison during the sweep.
  always @(negedge clk) begin
    if (sweep_on) begin
      chk("R1", "overlap", hi && lo, 1'b0);
      chk("R10", "high gate vs model", hi, mode == 1);
      chk("R10", "low gate vs model", lo, mode == 3);
    end
  end

  initial begin
    int r;
    bit [15:0] lfsr;
    tick(3);
    chk("R2", "high in reset", hi, 1'b0);
    chk("R2", "low in reset", lo, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R2", "high after reset", hi, 1'b0);
    chk("R2", "low after reset", lo, 1'b0);

    // Enable with command high, gate flag already low: high side after 3 negedges.
    run_en = 1; pwm = 1; lg_raw = 1; sw_raw = 0;
    tick(2);
    chk("R10", "high not before sync", hi, 1'b0);
    tick(1);
    chk("R10", "high after sync", hi, 1'b1);

    // Watchdog: switch node never falls.
    pwm = 0;
    tick(1);
    chk("R3", "high released", hi, 1'b0);
    tick(WD - 1);
    chk("R7", "low before timeout", lo, 1'b0);
    tick(1);
    chk("R7", "low at timeout", lo, 1'b1);

    // Low side releases; high waits for the gate flag.
    lg_raw = 0;
    tick(3);
    pwm = 1;
    tick(1);
    chk("R5", "low released", lo, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R6", "high held without gate flag", hi, 1'b0);
    end
    lg_raw = 1;
    tick(2);
    chk("R10", "high not before flag sync", hi, 1'b0);
    tick(1);
    chk("R6", "high after gate flag", hi, 1'b1);

    // Switch-node flag arrives mid-wait.
    pwm = 0;
    tick(1);
    chk("R3", "high released", hi, 1'b0);
    tick(2);
    sw_raw = 1;
    tick(2);
    chk("R4", "low not before flag sync", lo, 1'b0);
    tick(1);
    chk("R4", "low after switch-node flag", lo, 1'b1);
    sw_raw = 0;
    tick(3);

    // Reversal during a watchdog wait.
    pwm = 1;
    wait_hi_on();
    lg_raw = 0;
    tick(3);
    pwm = 0;
    tick(8);
    chk("R8", "low still waiting", lo, 1'b0);
    pwm = 1;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      chk("R8", "both off during reversal", hi | lo, 1'b0);
    end
    pwm = 0;
    tick(WD);
    chk("R8", "watchdog restarted, low still off", lo, 1'b0);
    tick(1);
    chk("R8", "low after full restarted timeout", lo, 1'b1);

    // Supervisor disable.
    lg_raw = 1;
    pwm = 1;
    wait_hi_on();
    run_en = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R9", "high off while disabled", hi, 1'b0);
      chk("R9", "low off while disabled", lo, 1'b0);
      pwm = ~pwm;
    end
    pwm = 0; sw_raw = 1;
    tick(3);
    run_en = 1;
    tick(1);
    chk("R9", "restart from both off", lo, 1'b0);
    tick(1);
    chk("R9", "low after restart", lo, 1'b1);

    // Pseudo-random sweep against the model.
    sweep_on = 1;
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      if (r[3:0] == 4'd0) run_en = ~run_en;
      else if (!run_en && r[1]) run_en = 1;
      if (r[7:5] == 3'd0) pwm = ~pwm;
      sw_raw = r[9] | (r[10] & r[11]);
      lg_raw = r[12] & r[13];
      tick(1);
    end
    sweep_on = 0;
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule